// File: doc/BRIEF.md
# Network Status LED Driver with Pulse Stretcher

This block turns a vector of eleven network status signals into four LED pin drives. Each LED owns a small configuration register. The register holds one enable bit per status signal, a stretch-enable bit and a drive-mode bit. The statuses an LED has enabled are merged into one indication. That indication can be lengthened by a short shift-register stretcher so that events only microseconds long stay visible for tens of milliseconds. The pin is then driven either as an active-low open-drain output (a value plus an output enable) or as an active-high push-pull output.

A built-in divider makes a one-cycle slow tick from the system clock, and this tick clocks every stretcher. Configuration is written through parallel inputs: one write strobe per LED and a shared data word. After reset, each LED has a fixed status selection, open-drain drive and stretching turned on.

Top module: `led_status_mux`

## Requirements
- R1: An LED's indication is high in the same cycle that any status input whose enable bit is set in that LED's register is high. Status inputs whose enable bit is clear have no effect. The status bit order is 0 collision, 1 full-duplex link, 2 half-duplex link, 3 jabber, 4 receive match, 5 receive polarity, 6 receive activity, 7 wake-up frame, 8 transceiver off, 9 MII enabled, 10 transmit activity.
- R2: A high `cfg_wr_i[n]` loads `cfg_wdata_i` into LED n's register at the clock edge. The new value takes effect from the next cycle and the old value stays in force during the write cycle. The word layout is bit 12 push-pull mode, bit 11 stretch enable, bits 10..0 status enables.
- R3: While stretching is on and the indication is high, the LED is lit in that same cycle and all three stretcher stages are filled.
- R4: With the indication low, the stretcher shifts toward its output on each tick and feeds in a zero. The LED stays lit while any stage is set. With a tick period of D cycles, a single-cycle event lights the LED for between 2D+2 and 3D+1 cycles, depending on where the event falls relative to the tick.
- R5: When a fill and a tick fall in the same cycle, the fill wins and the shift is lost.
- R6: With stretching off, the LED follows the indication directly and goes dark in the first cycle the indication is low.
- R7: In open-drain mode (bit 12 = 0), `led_o` is always 0 and `led_oe_o` is high exactly while the LED is lit.
- R8: In push-pull mode (bit 12 = 1), `led_oe_o` is always 1 and `led_o` is high exactly while the LED is lit.
- R9: `tick_o` is a one-cycle pulse that repeats every TICK_DIV cycles.
- R10: After reset, all LEDs are dark (`led_o` = 0, `led_oe_o` = 0), open-drain and stretched. Their default selections are: LED0 either link status (bits 1, 2), LED1 receive activity (bit 6), LED2 receive polarity (bit 5), LED3 transmit activity (bit 10).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| status_i | input | 11 | Network status signals |
| cfg_wr_i | input | NUM_LED | Per-LED configuration write strobe |
| cfg_wdata_i | input | 13 | Configuration word |
| tick_o | output | 1 | Slow stretcher tick |
| led_o | output | NUM_LED | Pin value per LED |
| led_oe_o | output | NUM_LED | Pin output enable per LED |

## Verification
A stretcher fill and a tick shift can fall in the same cycle. The bench sets this up by watching `tick_o` and driving a one-cycle status event in exactly that tick cycle. The fill must win, and the measured lit length must come out at the maximum of 3D+1 cycles. An event placed one cycle before a tick must give the minimum of 2D+2 cycles, and an event placed mid-period must give a value in between. A scoreboard queue holds the length expected for each pulse and compares it with the length the monitor observes.

// File: rtl/led_stat_pkg.sv
package led_stat_pkg;
  localparam int unsigned STAT_W = 11;
  localparam int unsigned CFG_W  = STAT_W + 2;

  typedef enum int unsigned {
    ST_COLL     = 0,
    ST_FDLINK   = 1,
    ST_HDLINK   = 2,
    ST_JAB      = 3,
    ST_RXMATCH  = 4,
    ST_RXPOL    = 5,
    ST_RXACT    = 6,
    ST_WAKE     = 7,
    ST_XCVR_OFF = 8,
    ST_MII_ON   = 9,
    ST_TXACT    = 10
  } stat_idx_e;

  typedef struct packed {
    logic              totem;
    logic              stretch;
    logic [STAT_W-1:0] en;
  } led_cfg_t;

  // Reset value of one LED's configuration register
  function automatic led_cfg_t led_cfg_default(int unsigned idx);
    led_cfg_t c;
    c.totem   = 1'b0;
    c.stretch = 1'b1;
    c.en      = '0;
    case (idx)
      0: begin c.en[ST_FDLINK] = 1'b1; c.en[ST_HDLINK] = 1'b1; end
      1: c.en[ST_RXACT] = 1'b1;
      2: c.en[ST_RXPOL] = 1'b1;
      3: c.en[ST_TXACT] = 1'b1;
      default: c.en = '0;
    endcase
    return c;
  endfunction

  // Masked OR of the status vector
  function automatic logic led_combine(logic [STAT_W-1:0] st, logic [STAT_W-1:0] en);
    return |(st & en);
  endfunction
endpackage

// File: rtl/led_tick_gen.sv
module led_tick_gen #(
  parameter int unsigned DIV = 6578947
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick_o
);
  localparam int unsigned CW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q;
  logic          at_end;

  assign at_end = (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt_q <= '0;
    else if (at_end) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = at_end;

  generate
    if (DIV > 1) begin : g_chk
      p_tick_isolated_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);
      p_tick_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> (cnt_q == '0));
    end
  endgenerate
endmodule

// File: rtl/led_channel.sv
module led_channel
  import led_stat_pkg::*;
#(
  parameter int unsigned SR_W = 3,
  parameter int unsigned IDX  = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic [STAT_W-1:0] status_i,
  input  logic              cfg_wr_i,
  input  led_cfg_t          cfg_wdata_i,
  output logic              led_o,
  output logic              led_oe_o
);
  led_cfg_t          cfg_q;
  logic              hit;
  logic [SR_W-1:0]   sr_q;
  logic              held;
  logic              lit;

  always_ff @(posedge clk) begin
    if (!rst_n)        cfg_q <= led_cfg_default(IDX);
    else if (cfg_wr_i) cfg_q <= cfg_wdata_i;
  end

  assign hit = led_combine(status_i, cfg_q.en);

  // Fill dominates shift; serial input is zero
  always_ff @(posedge clk) begin
    if (!rst_n)      sr_q <= '0;
    else if (hit)    sr_q <= '1;
    else if (tick_i) sr_q <= {sr_q[SR_W-2:0], 1'b0};
  end

  assign held     = |sr_q;
  assign lit      = cfg_q.stretch ? (hit | held) : hit;
  assign led_o    = cfg_q.totem & lit;
  assign led_oe_o = cfg_q.totem | lit;

  p_cfg_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr_i |=> (cfg_q == $past(cfg_wdata_i)));
  p_fill_r3: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> (&sr_q));
  p_lit_on_hit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> (cfg_q.totem ? led_o : led_oe_o));
  p_shift_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!hit && tick_i) |=> (sr_q == {$past(sr_q[SR_W-2:0]), 1'b0}));
  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!hit && !tick_i) |=> $stable(sr_q));
  p_fill_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && tick_i) |=> (&sr_q));
  p_direct_dark_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_q.stretch && !hit) |-> !(cfg_q.totem ? led_o : led_oe_o));
  p_od_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_q.totem |-> !led_o);
  p_tp_drive_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_q.totem |-> led_oe_o);
endmodule

// File: rtl/led_status_mux.sv
module led_status_mux
  import led_stat_pkg::*;
#(
  parameter int unsigned NUM_LED  = 4,
  parameter int unsigned TICK_DIV = 6578947,
  parameter int unsigned SR_W     = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [STAT_W-1:0]  status_i,
  input  logic [NUM_LED-1:0] cfg_wr_i,
  input  logic [CFG_W-1:0]   cfg_wdata_i,
  output logic               tick_o,
  output logic [NUM_LED-1:0] led_o,
  output logic [NUM_LED-1:0] led_oe_o
);
  logic     tick;
  led_cfg_t wdata;

  assign wdata  = led_cfg_t'(cfg_wdata_i);
  assign tick_o = tick;

  led_tick_gen #(.DIV(TICK_DIV)) u_tick (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick_o (tick)
  );

  generate
    for (genvar i = 0; i < NUM_LED; i++) begin : g_led
      led_channel #(.SR_W(SR_W), .IDX(i)) u_ch (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick_i      (tick),
        .status_i    (status_i),
        .cfg_wr_i    (cfg_wr_i[i]),
        .cfg_wdata_i (wdata),
        .led_o       (led_o[i]),
        .led_oe_o    (led_oe_o[i])
      );
    end
  endgenerate

  p_reset_dark_r10: assert property (@(posedge clk)
    !rst_n |=> (led_o == '0));
endmodule

// File: tb/led_status_mux_bench.sv
module led_status_mux_bench;
  localparam int D  = 8;
  localparam int NL = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [10:0]   st = '0;
  logic [NL-1:0] wr = '0;
  logic [12:0]   wdata = '0;
  logic          tick;
  logic [NL-1:0] led, oe;

  int n_chk = 0;
  int n_bad = 0;
  int exp_q[$];
  bit mon_on = 1'b0;
  int run = 0;

  always #2 clk = ~clk;

  led_status_mux #(.NUM_LED(NL), .TICK_DIV(D), .SR_W(3)) u_led_status_mux (
    .clk(clk), .rst_n(rst_n), .status_i(st), .cfg_wr_i(wr),
    .cfg_wdata_i(wdata), .tick_o(tick), .led_o(led), .led_oe_o(oe)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  task automatic cfg_write(input int idx, input logic [12:0] w);
    @(negedge clk);
    wr = '0; wr[idx] = 1'b1; wdata = w;
    @(negedge clk);
    wr = '0;
  endtask

  task automatic find_tick();
    @(negedge clk);
    while (!tick) @(negedge clk);
  endtask

  // Driver: one-cycle event on full-duplex link, expected lit length queued
  task automatic pulse_led0(input int wait_after_tick, input int exp_len, input string req);
    exp_q.push_back(exp_len);
    find_tick();
    repeat (wait_after_tick) @(negedge clk);
    st = '0; st[1] = 1'b1;
    #1 chk(oe[0] === 1'b1, req, int'(oe[0]), 1);
    @(negedge clk);
    st = '0;
    repeat (4 * D) @(negedge clk);
  endtask

  // Monitor: measures LED0 lit runs and compares against the queue
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (mon_on) begin
        if (oe[0]) run++;
        else if (run > 0) begin
          if (exp_q.size() == 0) chk(1'b0, "R4 unexpected pulse", run, 0);
          else begin
            int e;
            e = exp_q.pop_front();
            chk(run == e, "R4/R5 stretch length", run, e);
          end
          run = 0;
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    int t0, t1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk(oe === 4'b0000, "R10 reset oe", int'(oe), 0);
    chk(led === 4'b0000, "R10 reset led", int'(led), 0);

    // R10 default selections
    @(negedge clk); st = '0; st[6] = 1'b1;
    #1 chk(oe === 4'b0010, "R10 default rx activity on LED1", int'(oe), 2);
    @(negedge clk); st = '0; st[5] = 1'b1;
    #1 chk(oe[2] === 1'b1, "R10 default rx polarity on LED2", int'(oe[2]), 1);
    @(negedge clk); st = '0;
    repeat (4 * D) @(negedge clk);
    #1 chk(oe === 4'b0000, "R4 stretch drains to dark", int'(oe), 0);

    // R9 tick period
    find_tick(); t0 = $time;
    @(negedge clk);
    #1 chk(tick === 1'b0, "R9 tick one cycle", int'(tick), 0);
    find_tick(); t1 = $time;
    chk((t1 - t0) / 4 == D, "R9 tick period", (t1 - t0) / 4, D);

    // R4/R5 stretch lengths on LED0
    mon_on = 1'b1;
    pulse_led0(0, 3 * D + 1, "R5 fill with tick, lit at once R3");
    pulse_led0(D - 1, 2 * D + 2, "R4 min case, lit at once R3");
    pulse_led0(3, 3 * D - 2, "R4 mid-phase case");
    mon_on = 1'b0;
    chk(exp_q.size() == 0, "R4 all pulses seen", exp_q.size(), 0);

    // R1, R6, R7: LED1 collision|jabber, direct, open-drain
    cfg_write(1, {1'b0, 1'b0, 11'h009});
    st = '0; st[0] = 1'b1;
    #1 chk(oe[1] === 1'b1, "R1 enabled collision", int'(oe[1]), 1);
    chk(led[1] === 1'b0, "R7 open-drain value low", int'(led[1]), 0);
    @(negedge clk); st = '0; st[6] = 1'b1;
    #1 chk(oe[1] === 1'b0, "R1 disabled status ignored", int'(oe[1]), 0);
    @(negedge clk); st = '0; st[3] = 1'b1;
    #1 chk(oe[1] === 1'b1, "R1 enabled jabber", int'(oe[1]), 1);
    @(negedge clk); st = '0;
    #1 chk(oe[1] === 1'b0, "R6 no stretch, dark at once", int'(oe[1]), 0);
    @(negedge clk);
    #1 chk(oe[1] === 1'b0, "R6 stays dark", int'(oe[1]), 0);

    // R8 push-pull on LED2, transmit only
    cfg_write(2, {1'b1, 1'b0, 11'h400});
    st = '0; st[10] = 1'b1;
    #1 chk(led[2] === 1'b1 && oe[2] === 1'b1, "R8 push-pull lit", {led[2], oe[2]}, 3);
    @(negedge clk); st = '0;
    #1 chk(led[2] === 1'b0 && oe[2] === 1'b1, "R8 push-pull dark", {led[2], oe[2]}, 1);

    // R2 write timing on LED3 (let default transmit stretch drain first)
    repeat (4 * D) @(negedge clk);
    st = '0; st[0] = 1'b1; wr = 4'b1000; wdata = {1'b0, 1'b0, 11'h001};
    #1 chk(oe[3] === 1'b0, "R2 old config during write", int'(oe[3]), 0);
    @(negedge clk); wr = '0;
    #1 chk(oe[3] === 1'b1, "R2 new config after write", int'(oe[3]), 1);
    @(negedge clk); st = '0;
    #1 chk(oe[3] === 1'b0, "R2 new config has no stretch", int'(oe[3]), 0);

    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule